// File: doc/BRIEF.md
# I2C Master Framing Control Register

This block is the framing control and status register of an I2C master. It watches the shared data and clock lines for Start and Stop conditions from any master on the bus and keeps a bus-busy flag. It also keeps a flag that shows whether this device currently owns the bus. Software asks for a Start or a repeated Start by writing request bits. The block hands each request to the bit-level engine as a one-cycle strobe. The request bit clears itself when the engine reports that the condition has been produced.

A Start request made while another master holds the bus stays pending and goes out as soon as the bus frees. A repeated-Start request goes out only while this device owns the bus. The register is byte wide with a single write strobe, and it reads back continuously. Byte shifting, acknowledge handling and clock generation belong to the engine and are not part of this block.

Top module: `i2c_frame_ctl`

## Requirements
- R1: While `rst` is high, or while `enable` is low, every register bit is held at 0. A cycle with `enable` low leaves `reg_rdata` equal to 0x00 after the next clock edge.
- R2: `reg_rdata[7:4]` always reads 0. Writes to bits 7:4, and to the read-only bits 3 and 2, have no effect.
- R3: Bit 3 (busy) becomes 1 when a Start is seen: a falling SDA edge while SCL is high. It becomes 0 when a Stop is seen: a rising SDA edge while SCL is high. This applies to conditions from any master. With the default two synchronizer stages, the flag changes on the third rising clock edge after the line changes.
- R4: Writing 1 to bit 0 sets the Start request. While the request is set, busy is 0 and nothing is outstanding, `start_strobe` pulses high for exactly one cycle, on the clock edge after busy is seen at 0. While busy is 1 the request stays set and no strobe is issued.
- R5: An `eng_done` pulse that answers a Start strobe clears bit 0 and sets bit 2 (master mode).
- R6: Writing 1 to bit 1 sets the repeated-Start request. `restart_strobe` pulses for one cycle only while bit 2 is 1. Otherwise bit 1 stays set and no strobe is issued.
- R7: An `eng_done` pulse that answers a repeated-Start strobe clears bit 1 and leaves bit 2 at 1.
- R8: A pulse on `own_stop_done` (a Stop generated by this device) clears bit 2 on the next clock edge.
- R9: Writing 0 to bit 0 or bit 1 does not withdraw a pending request. Only hardware clears request bits.
- R10: An SDA edge while SCL is low is not a bus condition and leaves busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; while low the register is held in reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data {0, busy, master, restart req, start req} |
| sda_in | input | 1 | Raw SDA line sample |
| scl_in | input | 1 | Raw SCL line sample |
| start_strobe | output | 1 | One-cycle request to the engine to produce a Start |
| restart_strobe | output | 1 | One-cycle request to the engine to produce a repeated Start |
| eng_done | input | 1 | Engine pulse: the requested condition has been produced |
| own_stop_done | input | 1 | Engine pulse: this device has produced a Stop |

## Verification
The bench builds the block with its defaults: an 8-bit register and two synchronizer stages. With these values each bus condition reaches the busy flag exactly three edges after the line moves, so the bench can check both the cycle before the change and the cycle of the change. The short path also keeps in reach the cases where a Start is pending behind another master and goes out on the edge after that master's Stop. The bench checks a repeated Start refused outside master mode, SDA toggling while SCL is low, and a clear through the enable input.

// File: rtl/i2c_frame_pkg.sv
package i2c_frame_pkg;
  localparam int BUSY_BIT    = 3;
  localparam int MASTER_BIT  = 2;
  localparam int RESTART_BIT = 1;
  localparam int START_BIT   = 0;
  localparam int USED_BITS   = 4;

  typedef enum logic [1:0] {
    ISS_IDLE    = 2'd0,
    ISS_START   = 2'd1,
    ISS_RESTART = 2'd2
  } issue_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic sda_s,
  input  logic scl_s,
  output logic busy
);
  logic sda_q;
  logic scl_q;
  logic start_seen;
  logic stop_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_s;
      scl_q <= scl_s;
    end
  end

  // Condition only when SCL is high both before and after the SDA edge
  assign start_seen = sda_q & ~sda_s & scl_q & scl_s;
  assign stop_seen  = ~sda_q & sda_s & scl_q & scl_s;

  always_ff @(posedge clk) begin
    if (rst)             busy <= 1'b0;
    else if (start_seen) busy <= 1'b1;
    else if (stop_seen)  busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_req_ctl.sv
module i2c_req_ctl
  import i2c_frame_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic set_start,
  input  logic set_restart,
  input  logic busy,
  input  logic eng_done,
  input  logic own_stop_done,
  output logic start_req,
  output logic restart_req,
  output logic master,
  output logic start_strobe,
  output logic restart_strobe
);
  issue_e state;
  logic   go_start;
  logic   go_restart;
  logic   done_start;
  logic   done_restart;

  assign go_start     = (state == ISS_IDLE) && start_req && !busy;
  assign go_restart   = (state == ISS_IDLE) && !go_start && restart_req && master;
  assign done_start   = (state == ISS_START) && eng_done;
  assign done_restart = (state == ISS_RESTART) && eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ISS_IDLE;
      start_strobe   <= 1'b0;
      restart_strobe <= 1'b0;
    end else begin
      start_strobe   <= go_start;
      restart_strobe <= go_restart;
      if (go_start)                       state <= ISS_START;
      else if (go_restart)                state <= ISS_RESTART;
      else if (done_start || done_restart) state <= ISS_IDLE;
    end
  end

  // A new write of 1 wins over a hardware clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      start_req   <= 1'b0;
      restart_req <= 1'b0;
    end else begin
      start_req   <= (start_req & ~done_start) | (wr & set_start);
      restart_req <= (restart_req & ~done_restart) | (wr & set_restart);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                master <= 1'b0;
    else if (done_start)    master <= 1'b1;
    else if (own_stop_done) master <= 1'b0;
  end
endmodule

// File: rtl/i2c_frame_ctl.sv
module i2c_frame_ctl
  import i2c_frame_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sda_in,
  input  logic             scl_in,
  output logic             start_strobe,
  output logic             restart_strobe,
  input  logic             eng_done,
  input  logic             own_stop_done
);
  localparam int PAD_W = REG_W - USED_BITS;

  logic blk_rst;
  logic sda_s;
  logic scl_s;
  logic busy;
  logic master;
  logic start_req;
  logic restart_req;
  logic unused_wr_bits;

  assign blk_rst        = rst | ~enable;
  assign unused_wr_bits = ^reg_wdata[REG_W-1:RESTART_BIT+1];

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst(blk_rst), .d(sda_in), .q(sda_s)
  );
  i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst(blk_rst), .d(scl_in), .q(scl_s)
  );

  i2c_cond_detect u_det (
    .clk(clk), .rst(blk_rst), .sda_s(sda_s), .scl_s(scl_s), .busy(busy)
  );

  i2c_req_ctl u_req (
    .clk(clk),
    .rst(blk_rst),
    .wr(reg_wr),
    .set_start(reg_wdata[START_BIT]),
    .set_restart(reg_wdata[RESTART_BIT]),
    .busy(busy),
    .eng_done(eng_done),
    .own_stop_done(own_stop_done),
    .start_req(start_req),
    .restart_req(restart_req),
    .master(master),
    .start_strobe(start_strobe),
    .restart_strobe(restart_strobe)
  );

  assign reg_rdata = {{PAD_W{1'b0}}, busy, master, restart_req, start_req};
endmodule

// File: rtl/i2c_frame_ctl_chk.sv
module i2c_frame_ctl_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [REG_W-1:0] reg_rdata,
  input logic             start_strobe,
  input logic             restart_strobe,
  input logic             eng_done,
  input logic             own_stop_done
);
  // R1
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (reg_rdata == '0));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:4] == '0);

  // R4
  start_gated_chk: assert property (@(posedge clk) disable iff (rst)
    start_strobe |-> ($past(reg_rdata[0]) && !$past(reg_rdata[3])));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_strobe |=> !start_strobe);

  // R6
  restart_gated_chk: assert property (@(posedge clk) disable iff (rst)
    restart_strobe |-> ($past(reg_rdata[1]) && $past(reg_rdata[2])));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_strobe, restart_strobe}));

  // R8
  own_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (own_stop_done && !eng_done) |=> !reg_rdata[2]);
endmodule

bind i2c_frame_ctl i2c_frame_ctl_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .enable(enable),
  .reg_rdata(reg_rdata),
  .start_strobe(start_strobe),
  .restart_strobe(restart_strobe),
  .eng_done(eng_done),
  .own_stop_done(own_stop_done)
);

// File: tb/i2c_frame_ctl_test.sv
module i2c_frame_ctl_test;
  localparam int REG_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable = 1'b1;
  logic             reg_wr = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             sda_in = 1'b1;
  logic             scl_in = 1'b1;
  logic             start_strobe;
  logic             restart_strobe;
  logic             eng_done = 1'b0;
  logic             own_stop_done = 1'b0;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  byte exp_q[$];

  always #5 clk = ~clk;

  i2c_frame_ctl #(.REG_W(REG_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .enable(enable), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
    .scl_in(scl_in), .start_strobe(start_strobe),
    .restart_strobe(restart_strobe), .eng_done(eng_done),
    .own_stop_done(own_stop_done)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [REG_W-1:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    step(1);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic expect_strobe(byte kind);
    exp_q.push_back(kind);
  endtask

  // Monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (!rst && (start_strobe || restart_strobe)) begin
      byte got;
      got = start_strobe ? "S" : "R";
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R6 unexpected strobe actual=%c expected=none", got);
      end else begin
        byte want;
        want = exp_q.pop_front();
        if (got != want) begin
          errors++;
          $display("FAIL R4/R6 strobe kind actual=%c expected=%c", got, want);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(5);
    rst = 1'b0;
    step(1);
    check("R1 reset value", reg_rdata, 8'h00);

    wr(8'hFC);
    check("R2 reserved and read-only bits", reg_rdata, 8'h00);

    // SDA moves while SCL low: no condition
    scl_in = 1'b0; step(1);
    sda_in = 1'b0; step(4);
    sda_in = 1'b1; step(4);
    scl_in = 1'b1; step(4);
    check("R10 SDA edge with SCL low", reg_rdata[3], 1'b0);

    // Another master issues Start
    sda_in = 1'b0;
    step(2);
    check("R3 busy before third edge", reg_rdata[3], 1'b0);
    step(1);
    check("R3 busy after foreign Start", reg_rdata, 8'h08);

    // Start request held while busy
    wr(8'h01);
    step(10);
    check("R4 start pending while busy", reg_rdata, 8'h09);
    wr(8'h00);
    check("R9 write 0 keeps request", reg_rdata, 8'h09);

    // Foreign Stop frees the bus, pending Start goes out
    expect_strobe("S");
    sda_in = 1'b1;
    step(3);
    check("R3 busy cleared by Stop", reg_rdata[3], 1'b0);
    check("R4 no strobe same cycle", start_strobe, 1'b0);
    step(1);
    check("R4 strobe after busy clears", start_strobe, 1'b1);
    step(1);
    check("R4 strobe one cycle", start_strobe, 1'b0);

    // Engine produces the Start on the bus
    sda_in = 1'b0;
    eng_done = 1'b1;
    step(1);
    eng_done = 1'b0;
    check("R5 done clears start, sets master", reg_rdata, 8'h04);
    step(2);
    check("R3 busy from own Start", reg_rdata, 8'h0C);

    // Repeated Start while master
    expect_strobe("R");
    wr(8'h02);
    check("R6 restart bit set", reg_rdata, 8'h0E);
    step(1);
    check("R6 restart strobe", restart_strobe, 1'b1);
    step(2);
    eng_done = 1'b1;
    step(1);
    eng_done = 1'b0;
    check("R7 done clears restart, master kept", reg_rdata, 8'h0C);

    // Own Stop
    sda_in = 1'b1;
    own_stop_done = 1'b1;
    step(1);
    own_stop_done = 1'b0;
    check("R8 own Stop clears master", reg_rdata, 8'h08);
    step(2);
    check("R3 busy cleared by own Stop", reg_rdata, 8'h00);

    // Repeated Start refused outside master mode
    wr(8'h02);
    step(10);
    check("R6 restart pending without master", reg_rdata, 8'h02);

    // Disable clears everything
    enable = 1'b0;
    step(1);
    check("R1 disable clears register", reg_rdata, 8'h00);
    enable = 1'b1;
    step(2);
    check("R1 stays clear after enable", reg_rdata, 8'h00);

    check("R4 all expected strobes seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule